// File: doc/BRIEF.md
# Signed Long-by-Word Divide Unit

This block divides a signed double-width dividend by a signed single-width divisor over several clock cycles. It is meant for the arithmetic side of a 16-bit minicomputer-style datapath. The dividend arrives as a high word and a low word, and together they form a 2W-bit two's-complement value. The divisor is a W-bit two's-complement value. The block returns a W-bit quotient, a W-bit remainder and four condition flags: negative, zero, overflow and carry.

The block works on magnitudes. It first strips the signs. It then tests for a zero divisor and for a dividend that is far too large, and after that it runs a restoring shift-and-subtract loop that produces W+1 quotient bits. A final stage restores the signs, range-checks the quotient and builds the flags. The quotient truncates toward zero, and the remainder takes the sign of the dividend.

A caller raises `start` for one cycle with the operands valid. It then waits for the single-cycle `done` pulse. The results and flags stay on the outputs until the next operation completes.

Top module: `sdiv_unit`

## Requirements
- R1: While reset is held, `done`, `busy`, `quo`, `rem` and all four flags read zero.
- R2: When the true quotient fits in W signed bits, `quo` is the quotient truncated toward zero. `rem` is the dividend minus quo times divisor, so it takes the dividend's sign. The flags are N = `quo` sign bit, Z = (`quo` == 0), V = 0 and C = 0. Example: 34 / -5 gives -6 remainder 4.
- R3: A zero divisor gives N = 0, Z = 1, V = 1 and C = 1.
- R4: When the true quotient is above 2^(W-1)-1 or below -2^(W-1), the flags are V = 1, C = 0 and Z = 0. N is 1 exactly when the true quotient is negative, which is when the operand signs differ. `quo` and `rem` carry no meaning in this case.
- R5: A quotient of exactly -2^(W-1) is representable. It gives V = 0 and N = 1, with the correct remainder.
- R6: `done` is high for exactly one cycle per operation. `busy` is high from the cycle after an accepted `start` until the cycle in which `done` is high, and it is low in that cycle.
- R7: Count cycles after the edge that accepts `start`. `done` arrives 2 cycles later when the divisor is zero, or when |dividend| >= |divisor| * 2^(W+1). For every other operation it arrives W+3 cycles later.
- R8: A `start` raised while `busy` is high is ignored. The running operation completes with its own operands.
- R9: `quo`, `rem` and the flags change only in a cycle in which `done` is high. They hold their values between operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division; accepted only while idle |
| dvd_hi | input | W | Upper word of the signed dividend |
| dvd_lo | input | W | Lower word of the signed dividend |
| dvsr | input | W | Signed divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: results and flags updated |
| quo | output | W | Signed quotient |
| rem | output | W | Signed remainder |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag (divide by zero) |

## Verification
The hardest situations to reach are the ones where the quotient magnitude sits exactly at the representable limit. A magnitude of 2^(W-1) is legal when the result is negative and is an overflow when it is positive. These cases only show up after the full iteration, not in the early range test. Near these limits the dividend has to be chosen to within one unit of divisor × limit in every sign quadrant. The bench therefore sweeps every dividend and divisor pair of a 4-bit-word instance, which hits each such boundary in all four quadrants, and computes quotient, remainder, flags and latency arithmetically. A second bench instance uses the default 16-bit words and runs directed operands just either side of the quotient limits. On a share of the operations the bench raises `start` mid-operation with different operands, to show that the request is dropped.

// File: rtl/sdiv_pkg.sv
`timescale 1ns/1ps
package sdiv_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_RUN, ST_FIN} sdiv_state_e;
  typedef enum logic [1:0] {END_NORMAL, END_ZERO, END_BIG} sdiv_end_e;
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } sdiv_flags_t;
endpackage

// File: rtl/sdiv_prep.sv
`timescale 1ns/1ps
// Splits the signed operands into sign bits and unsigned magnitudes.
module sdiv_prep #(
  parameter int W = 16
) (
  input  logic [W-1:0]   hi,
  input  logic [W-1:0]   lo,
  input  logic [W-1:0]   dr,
  output logic [2*W-1:0] dd_mag,
  output logic [W-1:0]   dr_mag,
  output logic           dd_neg,
  output logic           dr_neg,
  output logic           dr_zero
);
  localparam int DW = 2 * W;

  logic [DW-1:0] dd;

  always_comb begin
    dd      = {hi, lo};
    dd_neg  = hi[W-1];
    dr_neg  = dr[W-1];
    dd_mag  = dd_neg ? (~dd + {{(DW-1){1'b0}}, 1'b1}) : dd;
    dr_mag  = dr_neg ? (~dr + {{(W-1){1'b0}}, 1'b1}) : dr;
    dr_zero = (dr == '0);
  end
endmodule

// File: rtl/sdiv_iter.sv
`timescale 1ns/1ps
// Magnitude datapath: captures operands, runs restoring steps.
module sdiv_iter #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [2*W-1:0] dd_mag,
  input  logic [W-1:0]   dr_mag,
  input  logic           dd_neg,
  input  logic           dr_neg,
  input  logic           dr_zero,
  output logic [W:0]     q_mag,
  output logic [W-1:0]   r_mag,
  output logic           q_neg,
  output logic           r_neg,
  output logic           zero,
  output logic           big
);
  localparam int DW = 2 * W;
  localparam int QB = W + 1;

  logic [W-1:0]  dr_q;
  logic [W-1:0]  rem_q;
  logic [QB-1:0] sh_q;
  logic [W:0]    cand;
  logic [W:0]    diff;
  logic          ge;
  logic          big_c;

  // Upper dividend bits already reaching the divisor mean the quotient
  // needs more than QB bits.
  assign big_c = ({1'b0, dd_mag[DW-1:QB]} >= dr_mag);

  always_comb begin
    cand = {rem_q, sh_q[QB-1]};
    diff = cand - {1'b0, dr_q};
    ge   = (cand >= {1'b0, dr_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dr_q  <= '0;
      rem_q <= '0;
      sh_q  <= '0;
      q_neg <= 1'b0;
      r_neg <= 1'b0;
      zero  <= 1'b0;
      big   <= 1'b0;
    end else if (load) begin
      dr_q  <= dr_mag;
      rem_q <= {1'b0, dd_mag[DW-1:QB]};
      sh_q  <= dd_mag[QB-1:0];
      q_neg <= dd_neg ^ dr_neg;
      r_neg <= dd_neg;
      zero  <= dr_zero;
      big   <= big_c;
    end else if (step) begin
      rem_q <= ge ? diff[W-1:0] : cand[W-1:0];
      sh_q  <= {sh_q[QB-2:0], ge};
    end
  end

  assign q_mag = sh_q;
  assign r_mag = rem_q;
endmodule

// File: rtl/sdiv_ctrl.sv
`timescale 1ns/1ps
// Sequencer: idle, early check, STEPS iterations, finish.
module sdiv_ctrl
  import sdiv_pkg::*;
#(
  parameter int STEPS = 17
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      dr_zero,
  input  logic      too_big,
  output logic      load,
  output logic      step,
  output logic      fin,
  output logic      busy,
  output sdiv_end_e kind
);
  localparam int CW = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  sdiv_state_e   state;
  logic [CW-1:0] cnt;

  always_comb begin
    load = (state == ST_IDLE) && start;
    step = (state == ST_RUN);
    fin  = (state == ST_FIN);
    busy = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      kind  <= END_NORMAL;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= ST_CHECK;
        ST_CHECK: begin
          cnt <= '0;
          if (dr_zero) begin
            kind  <= END_ZERO;
            state <= ST_FIN;
          end else if (too_big) begin
            kind  <= END_BIG;
            state <= ST_FIN;
          end else begin
            kind  <= END_NORMAL;
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdiv_post.sv
`timescale 1ns/1ps
// Sign restore, quotient range check and flag generation.
module sdiv_post
  import sdiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W:0]   q_mag,
  input  logic [W-1:0] r_mag,
  input  logic         q_neg,
  input  logic         r_neg,
  input  sdiv_end_e    kind,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output sdiv_flags_t  flags
);
  localparam logic [W:0] POS_LIM = {2'b00, {(W-1){1'b1}}};
  localparam logic [W:0] NEG_LIM = {2'b01, {(W-1){1'b0}}};

  logic         fits;
  logic [W-1:0] q_w;
  logic [W-1:0] q_s;
  logic [W-1:0] r_s;

  always_comb begin
    fits = q_neg ? (q_mag <= NEG_LIM) : (q_mag <= POS_LIM);
    q_w  = q_mag[W-1:0];
    q_s  = q_neg ? (~q_w + {{(W-1){1'b0}}, 1'b1}) : q_w;
    r_s  = r_neg ? (~r_mag + {{(W-1){1'b0}}, 1'b1}) : r_mag;
    quo  = '0;
    rem  = '0;
    case (kind)
      END_ZERO: flags = '{n: 1'b0, z: 1'b1, v: 1'b1, c: 1'b1};
      END_BIG:  flags = '{n: q_neg, z: 1'b0, v: 1'b1, c: 1'b0};
      default: begin
        if (!fits) begin
          flags = '{n: q_neg, z: 1'b0, v: 1'b1, c: 1'b0};
        end else begin
          quo   = q_s;
          rem   = r_s;
          flags = '{n: q_s[W-1], z: (q_s == '0), v: 1'b0, c: 1'b0};
        end
      end
    endcase
  end
endmodule

// File: rtl/sdiv_unit.sv
`timescale 1ns/1ps
module sdiv_unit
  import sdiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] dvsr,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_v,
  output logic         flag_c
);
  localparam int DW = 2 * W;
  localparam int QB = W + 1;

  logic [DW-1:0] dd_mag;
  logic [W-1:0]  dr_mag;
  logic          dd_neg, dr_neg, dr_zero;
  logic [W:0]    q_mag;
  logic [W-1:0]  r_mag;
  logic          q_neg, r_neg, zero_q, big_q;
  logic          load, step, fin;
  sdiv_end_e     kind;
  logic [W-1:0]  quo_c, rem_c;
  sdiv_flags_t   flags_c;

  sdiv_prep #(.W(W)) u_prep (
    .hi(dvd_hi), .lo(dvd_lo), .dr(dvsr),
    .dd_mag(dd_mag), .dr_mag(dr_mag),
    .dd_neg(dd_neg), .dr_neg(dr_neg), .dr_zero(dr_zero)
  );

  sdiv_iter #(.W(W)) u_iter (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .dd_mag(dd_mag), .dr_mag(dr_mag),
    .dd_neg(dd_neg), .dr_neg(dr_neg), .dr_zero(dr_zero),
    .q_mag(q_mag), .r_mag(r_mag), .q_neg(q_neg), .r_neg(r_neg),
    .zero(zero_q), .big(big_q)
  );

  sdiv_ctrl #(.STEPS(QB)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .dr_zero(zero_q), .too_big(big_q),
    .load(load), .step(step), .fin(fin), .busy(busy), .kind(kind)
  );

  sdiv_post #(.W(W)) u_post (
    .q_mag(q_mag), .r_mag(r_mag), .q_neg(q_neg), .r_neg(r_neg),
    .kind(kind), .quo(quo_c), .rem(rem_c), .flags(flags_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      quo    <= '0;
      rem    <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_v <= 1'b0;
      flag_c <= 1'b0;
    end else begin
      done <= fin;
      if (fin) begin
        quo    <= quo_c;
        rem    <= rem_c;
        flag_n <= flags_c.n;
        flag_z <= flags_c.z;
        flag_v <= flags_c.v;
        flag_c <= flags_c.c;
      end
    end
  end
endmodule

// File: rtl/sdiv_unit_chk.sv
`timescale 1ns/1ps
module sdiv_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quo,
  input logic [W-1:0] rem,
  input logic         flag_n,
  input logic         flag_z,
  input logic         flag_v,
  input logic         flag_c
);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_start_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_zero_div_R3: assert property (@(posedge clk) disable iff (rst)
    (done && flag_c) |-> (flag_v && flag_z && !flag_n));

  assert_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (done && flag_v && !flag_c) |-> !flag_z);

  assert_result_flags_R2: assert property (@(posedge clk) disable iff (rst)
    (done && !flag_v) |-> ((flag_z == (quo == '0)) && (flag_n == quo[W-1]) && !flag_c));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(quo) && $stable(rem) && $stable({flag_n, flag_z, flag_v, flag_c})));
endmodule

bind sdiv_unit sdiv_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .quo(quo), .rem(rem), .flag_n(flag_n), .flag_z(flag_z),
  .flag_v(flag_v), .flag_c(flag_c)
);

// File: tb/sdiv_unit_tb.sv
`timescale 1ns/1ps
module sdiv_unit_tb;
  localparam int WB = 16;
  localparam int WS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          b_start = 1'b0;
  logic [WB-1:0] b_hi = '0, b_lo = '0, b_dr = '0;
  logic          b_busy, b_done, b_n, b_z, b_v, b_c;
  logic [WB-1:0] b_quo, b_rem;

  logic          s_start = 1'b0;
  logic [WS-1:0] s_hi = '0, s_lo = '0, s_dr = '0;
  logic          s_busy, s_done, s_n, s_z, s_v, s_c;
  logic [WS-1:0] s_quo, s_rem;

  int checks = 0;
  int errors = 0;

  sdiv_unit #(.W(WB)) u_dut (
    .clk(clk), .rst(rst), .start(b_start), .dvd_hi(b_hi), .dvd_lo(b_lo), .dvsr(b_dr),
    .busy(b_busy), .done(b_done), .quo(b_quo), .rem(b_rem),
    .flag_n(b_n), .flag_z(b_z), .flag_v(b_v), .flag_c(b_c)
  );

  sdiv_unit #(.W(WS)) u_dut_small (
    .clk(clk), .rst(rst), .start(s_start), .dvd_hi(s_hi), .dvd_lo(s_lo), .dvsr(s_dr),
    .busy(s_busy), .done(s_done), .quo(s_quo), .rem(s_rem),
    .flag_n(s_n), .flag_z(s_z), .flag_v(s_v), .flag_c(s_c)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic judge(input int w, input longint dd, input longint dr,
                       input longint aq, input longint ar, input logic [3:0] af,
                       input bit got, input int lat, input bit pulse_ok,
                       input bit busy_ok, input bit poke);
    longint lim, mask, add, adr, q, r;
    logic [3:0] ef;
    int elat;
    string tag;
    lim  = longint'(1) << (w - 1);
    mask = (longint'(1) << w) - 1;
    add  = (dd < 0) ? -dd : dd;
    adr  = (dr < 0) ? -dr : dr;
    q = 0;
    r = 0;
    if (dr == 0) begin
      ef = 4'b0111; elat = 2; tag = "R3";
    end else begin
      q = dd / dr;
      r = dd % dr;
      elat = (add >= (adr << (w + 1))) ? 2 : w + 3;
      if (q > lim - 1 || q < -lim) begin
        ef = {(q < 0), 1'b0, 1'b1, 1'b0}; tag = "R4";
      end else begin
        ef = {(q < 0), (q == 0), 1'b0, 1'b0};
        tag = (q == -lim) ? "R5" : "R2";
      end
    end
    if (!got) begin
      chk(1'b0, "R7", "no done", 0, longint'(elat));
      return;
    end
    chk(af == ef, tag, "flags nzvc", longint'(af), longint'(ef));
    if (!ef[1] && !ef[0]) begin
      chk((aq & mask) == (q & mask), poke ? "R8" : tag, "quotient", aq, q & mask);
      chk((ar & mask) == (r & mask), poke ? "R8" : "R2", "remainder", ar, r & mask);
    end
    chk(lat == elat, "R7", "latency", longint'(lat), longint'(elat));
    chk(pulse_ok, "R6", "done width", 0, 1);
    chk(busy_ok, "R6", "busy during run", 0, 1);
  endtask

  task automatic run_b(input logic [WB-1:0] hi, input logic [WB-1:0] lo,
                       input logic [WB-1:0] dr, input bit poke);
    int k;
    bit got, busy_ok, pulse_ok;
    longint aq, ar;
    logic [3:0] af;
    @(negedge clk);
    b_hi = hi; b_lo = lo; b_dr = dr; b_start = 1'b1;
    @(negedge clk);
    b_start = 1'b0;
    k = 0; got = 1'b0; busy_ok = 1'b1;
    while (!got && k < 64) begin
      if (poke && k == 1) begin
        b_start = 1'b1; b_hi = ~hi; b_lo = lo ^ 16'h5a5a; b_dr = dr + 16'd1;
      end else b_start = 1'b0;
      @(negedge clk);
      k++;
      if (b_done) got = 1'b1;
      else if (!b_busy) busy_ok = 1'b0;
    end
    b_start = 1'b0;
    aq = longint'(b_quo); ar = longint'(b_rem); af = {b_n, b_z, b_v, b_c};
    @(negedge clk);
    pulse_ok = !b_done;
    judge(WB, longint'($signed({hi, lo})), longint'($signed(dr)), aq, ar, af,
          got, k, pulse_ok, busy_ok, poke);
  endtask

  task automatic run_s(input logic [WS-1:0] hi, input logic [WS-1:0] lo,
                       input logic [WS-1:0] dr, input bit poke);
    int k;
    bit got, busy_ok, pulse_ok;
    longint aq, ar;
    logic [3:0] af;
    @(negedge clk);
    s_hi = hi; s_lo = lo; s_dr = dr; s_start = 1'b1;
    @(negedge clk);
    s_start = 1'b0;
    k = 0; got = 1'b0; busy_ok = 1'b1;
    while (!got && k < 64) begin
      if (poke && k == 1) begin
        s_start = 1'b1; s_hi = ~hi; s_lo = lo ^ 4'h5; s_dr = dr + 4'd3;
      end else s_start = 1'b0;
      @(negedge clk);
      k++;
      if (s_done) got = 1'b1;
      else if (!s_busy) busy_ok = 1'b0;
    end
    s_start = 1'b0;
    aq = longint'(s_quo); ar = longint'(s_rem); af = {s_n, s_z, s_v, s_c};
    @(negedge clk);
    pulse_ok = !s_done;
    judge(WS, longint'($signed({hi, lo})), longint'($signed(dr)), aq, ar, af,
          got, k, pulse_ok, busy_ok, poke);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [WB-1:0] held_q, held_r;
    repeat (3) @(negedge clk);
    // R1: reset state of both instances
    chk({b_done, b_busy, b_n, b_z, b_v, b_c} == 6'b0, "R1", "big ctrl/flags",
        longint'({b_done, b_busy, b_n, b_z, b_v, b_c}), 0);
    chk(b_quo == '0 && b_rem == '0, "R1", "big quo|rem", longint'({b_quo, b_rem}), 0);
    chk({s_done, s_busy, s_n, s_z, s_v, s_c, s_quo, s_rem} == '0, "R1", "small outputs",
        longint'({s_done, s_busy, s_n, s_z, s_v, s_c, s_quo, s_rem}), 0);
    rst = 1'b0;

    // Directed 16-bit cases: quadrants, zero divisor, quotient limits
    run_b(16'h0000, 16'h0000, 16'd3, 1'b0);       // R2 zero quotient
    run_b(16'h0000, 16'h0002, 16'd3, 1'b0);       // R2 2/3
    run_b(16'hffff, 16'hffff, 16'd3, 1'b0);       // R2 -1/3
    run_b(16'h0000, 16'd34, 16'd5, 1'b1);         // R2, R8
    run_b(16'h0000, 16'd34, 16'hfffb, 1'b0);      // R2 34/-5
    run_b(16'hffff, 16'hffde, 16'd5, 1'b1);       // R2 -34/5
    run_b(16'hffff, 16'hffde, 16'hfffb, 1'b0);    // R2 -34/-5
    run_b(16'h0000, 16'h0000, 16'h0000, 1'b0);    // R3
    run_b(16'hffff, 16'hffff, 16'h0000, 1'b1);    // R3
    run_b(16'hffff, 16'h8000, 16'hffff, 1'b0);    // R4 -32768/-1
    run_b(16'h7fff, 16'hffff, 16'h0001, 1'b0);    // R4 early
    run_b(16'h7fff, 16'hffff, 16'hffff, 1'b0);    // R4 N=1
    run_b(16'h8000, 16'h0000, 16'h0001, 1'b0);    // R4 N=1
    run_b(16'h8000, 16'h0000, 16'hffff, 1'b0);    // R4 N=0
    run_b(16'h4000, 16'h0000, 16'h8000, 1'b1);    // R5
    run_b(16'hc000, 16'h0002, 16'h7fff, 1'b0);    // R5
    run_b(16'h3fff, 16'h7fff, 16'h7fff, 1'b0);    // R2 max positive
    run_b(16'h3fff, 16'h8000, 16'h7fff, 1'b0);    // R4 just past limit
    run_b(16'hc000, 16'h0001, 16'h7fff, 1'b0);    // R4 just past negative limit

    // R9: results hold between operations
    run_b(16'h0000, 16'd34, 16'd5, 1'b0);
    held_q = b_quo; held_r = b_rem;
    b_hi = 16'h1234; b_lo = 16'h5678; b_dr = 16'd7;
    repeat (5) @(negedge clk);
    chk(b_quo == held_q && b_rem == held_r && b_quo == 16'd6, "R9", "held quotient",
        longint'(b_quo), 6);

    // Exhaustive sweep of the 4-bit instance
    for (int hi = 0; hi < 16; hi++)
      for (int lo = 0; lo < 16; lo++)
        for (int dr = 0; dr < 16; dr++)
          run_s(WS'(hi), WS'(lo), WS'(dr), ((hi + lo + dr) % 7) == 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule